// File: doc/BRIEF.md
# Triple 32-bit Timer Peripheral

This block is a memory-mapped peripheral with three independent 32-bit counters behind a simple register bus made of an address, write data, a write strobe, a read strobe and registered read data. Each counter has its own bank: a count value that software can read and overwrite, a reload value, and two compare values. One shared control word holds three bits per counter (run enable, clock source select, overflow interrupt enable) and one global direction bit.

On each cycle in which a counter is enabled and its chosen clock source is active, it steps by one. The source is either every peripheral clock cycle or a tick arriving on an asynchronous external input. When it passes its terminal value it loads its reload value and raises an overflow event. Compare hits and overflows set sticky bits in an interrupt status register. Software clears those bits by writing ones. The bits are qualified by a mask register and ORed into a single interrupt line.

Top module: `tmr_top`

## Requirements
- R1: Bank t (t = 0,1,2) sits at byte address 0x10*t with count at +0x0, reload at +0x4, compare 1 at +0x8, compare 2 at +0xC. Control is at 0x30, status at 0x34 and mask at 0x38. Any other address reads 0. Read data is registered and updates on the clock edge where the read strobe is high. Every register resets to 0.
- R2: For counter t, control bit 3t is run enable, bit 3t+1 is clock select and bit 3t+2 is overflow interrupt enable. Bit 9 set means count up and clear means count down. Control reads back its 10 bits.
- R3: With direction down, enable set and clock select 0, the count drops by exactly one per peripheral clock cycle.
- R4: Counting down, a step taken from a count of 0 loads the reload value and sets the counter's overflow status bit (bit 3t+2).
- R5: Counting up, a step taken from 0xFFFFFFFF loads the reload value and sets the overflow status bit. Otherwise the count rises by one per step.
- R6: Clearing the enable freezes the count. Setting it again resumes from the frozen value without a reload.
- R7: With clock select 1, the counter steps once per rising edge of the external tick input after a two-flop synchroniser. An input held high gives only one step.
- R8: A bus write to a count register in the same cycle as a step wins: the count takes the written value.
- R9: Status bit 3t (compare 1) or 3t+1 (compare 2) is set when a step moves the count to a value equal to that compare register. A reload result counts as such a value.
- R10: Status bits stay set until software writes 1 to them at 0x34. Writing 0 leaves a bit unchanged. A new event in the same cycle as the clear keeps the bit set.
- R11: The interrupt output is high when any status bit whose mask bit is 0 is set. An overflow bit also needs its counter's overflow interrupt enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick_i | input | 1 | Asynchronous external count tick |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt |

## Verification
Several properties are checked on every cycle:
- a count write always wins;
- a disabled count never moves;
- a down-counting count that is away from zero drops by exactly one;
- status bits never drop without a write to the status address;
- read data holds while no read is strobed;
- the interrupt is never raised without an unmasked status bit.

Other behaviours are shown only by the bench's scenarios, which measure them through bus reads after a known number of enabled cycles:
- the exact reload value after an overflow in both directions;
- compare hits on reloaded values;
- resume without reload;
- the external tick counting exactly one step per edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned FLDS_PER = 3;
  localparam logic [1:0] SH_BANK   = 2'd3;
  localparam logic [1:0] R_CNT     = 2'd0;
  localparam logic [1:0] R_RELOAD  = 2'd1;
  localparam logic [1:0] R_CMP1    = 2'd2;
  localparam logic [1:0] R_CMP2    = 2'd3;
  localparam logic [1:0] R_CTRL    = 2'd0;
  localparam logic [1:0] R_STAT    = 2'd1;
  localparam logic [1:0] R_MASK    = 2'd2;

  typedef struct packed {
    logic ovf_ie;
    logic ext_sel;
    logic run;
  } chan_cfg_t;
endpackage

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic pulse_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= tick_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign pulse_o = sync_q & ~prev_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             up_i,
  input  logic             cnt_we_i,
  input  logic             rld_we_i,
  input  logic             cmp1_we_i,
  input  logic             cmp2_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic [CNT_W-1:0] cmp1_o,
  output logic [CNT_W-1:0] cmp2_o,
  output logic             ovf_o,
  output logic             hit1_o,
  output logic             hit2_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, cmp1_q, cmp2_q;
  logic             wrap;
  logic             adv;

  assign adv = step_i & ~cnt_we_i;

  always_comb begin
    wrap  = up_i ? (&cnt_q) : (cnt_q == '0);
    cnt_d = cnt_q;
    if (cnt_we_i)      cnt_d = wdata_i;
    else if (step_i) begin
      if (wrap)        cnt_d = rld_q;
      else if (up_i)   cnt_d = cnt_q + 1'b1;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      cmp1_q <= '0;
      cmp2_q <= '0;
    end else begin
      if (cnt_we_i | step_i) cnt_q  <= cnt_d;
      if (rld_we_i)          rld_q  <= wdata_i;
      if (cmp1_we_i)         cmp1_q <= wdata_i;
      if (cmp2_we_i)         cmp2_q <= wdata_i;
    end
  end

  assign ovf_o  = adv & wrap;
  assign hit1_o = adv & (cnt_d == cmp1_q);
  assign hit2_o = adv & (cnt_d == cmp2_q);
  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign cmp1_o = cmp1_q;
  assign cmp2_o = cmp2_q;
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_TMR = 3,
  parameter int unsigned CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_tick_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              irq_o
);
  localparam int unsigned EVT_W  = FLDS_PER * NUM_TMR;
  localparam int unsigned CTRL_W = EVT_W + 1;
  localparam int unsigned DIR_B  = EVT_W;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [EVT_W-1:0]  status_q, status_d, mask_q, mask_d;
  logic [EVT_W-1:0]  evt, irq_qual;
  logic [CNT_W-1:0]  rdata_q, rdata_d;
  logic [NUM_TMR-1:0][CNT_W-1:0] cnt_bus, rld_bus, cmp1_bus, cmp2_bus;
  logic [1:0]        bank, reg_sel;
  logic              addr_ok, ext_pulse;
  chan_cfg_t         cfg [NUM_TMR];

  assign bank    = bus_addr_i[5:4];
  assign reg_sel = bus_addr_i[3:2];
  assign addr_ok = (bus_addr_i[7:6] == 2'b00) && (bus_addr_i[1:0] == 2'b00);

  tmr_ext_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (ext_tick_i),
    .pulse_o (ext_pulse)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_chan
    logic bank_wr;
    assign cfg[t]  = chan_cfg_t'(ctrl_q[FLDS_PER*t +: FLDS_PER]);
    assign bank_wr = bus_wr_i && addr_ok && (bank == 2'(t));

    tmr_channel #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_i    (cfg[t].run & (cfg[t].ext_sel ? ext_pulse : 1'b1)),
      .up_i      (ctrl_q[DIR_B]),
      .cnt_we_i  (bank_wr && (reg_sel == R_CNT)),
      .rld_we_i  (bank_wr && (reg_sel == R_RELOAD)),
      .cmp1_we_i (bank_wr && (reg_sel == R_CMP1)),
      .cmp2_we_i (bank_wr && (reg_sel == R_CMP2)),
      .wdata_i   (bus_wdata_i),
      .cnt_o     (cnt_bus[t]),
      .rld_o     (rld_bus[t]),
      .cmp1_o    (cmp1_bus[t]),
      .cmp2_o    (cmp2_bus[t]),
      .ovf_o     (evt[FLDS_PER*t+2]),
      .hit1_o    (evt[FLDS_PER*t]),
      .hit2_o    (evt[FLDS_PER*t+1])
    );

    assign irq_qual[FLDS_PER*t]   = 1'b1;
    assign irq_qual[FLDS_PER*t+1] = 1'b1;
    assign irq_qual[FLDS_PER*t+2] = cfg[t].ovf_ie;
  end

  always_comb begin
    logic sh_wr;
    sh_wr    = bus_wr_i && addr_ok && (bank == SH_BANK);
    ctrl_d   = ctrl_q;
    mask_d   = mask_q;
    status_d = status_q;
    if (sh_wr && reg_sel == R_CTRL) ctrl_d = bus_wdata_i[CTRL_W-1:0];
    if (sh_wr && reg_sel == R_MASK) mask_d = bus_wdata_i[EVT_W-1:0];
    if (sh_wr && reg_sel == R_STAT) status_d = status_q & ~bus_wdata_i[EVT_W-1:0];
    status_d = status_d | evt;
  end

  always_comb begin
    rdata_d = '0;
    if (addr_ok) begin
      if (bank == SH_BANK) begin
        case (reg_sel)
          R_CTRL:  rdata_d = CNT_W'(ctrl_q);
          R_STAT:  rdata_d = CNT_W'(status_q);
          R_MASK:  rdata_d = CNT_W'(mask_q);
          default: rdata_d = '0;
        endcase
      end else if (int'(bank) < NUM_TMR) begin
        case (reg_sel)
          R_CNT:    rdata_d = cnt_bus[bank];
          R_RELOAD: rdata_d = rld_bus[bank];
          R_CMP1:   rdata_d = cmp1_bus[bank];
          default:  rdata_d = cmp2_bus[bank];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      status_q <= '0;
      mask_q   <= '0;
      rdata_q  <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      status_q <= status_d;
      mask_q   <= mask_d;
      if (bus_rd_i) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = |(status_q & ~mask_q & irq_qual);
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned EVT_W = 9,
  parameter int unsigned CTRL_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        bus_addr_i,
  input logic [CNT_W-1:0]  bus_wdata_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [CNT_W-1:0]  bus_rdata_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt0,
  input logic [CTRL_W-1:0] ctrl,
  input logic [EVT_W-1:0]  status,
  input logic [EVT_W-1:0]  mask
);
  logic wr_cnt0, wr_stat;
  assign wr_cnt0 = bus_wr_i && (bus_addr_i == 8'h00);
  assign wr_stat = bus_wr_i && (bus_addr_i == 8'h34);

  AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt0 |=> (cnt0 == $past(bus_wdata_i))); // R8

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !wr_cnt0) |=> $stable(cnt0)); // R6

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !ctrl[1] && !ctrl[CTRL_W-1] && cnt0 != '0 && !wr_cnt0)
      |=> (cnt0 == $past(cnt0) - 1'b1)); // R3

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((status & $past(status)) == $past(status))); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> $stable(bus_rdata_o)); // R1

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((status & ~mask) != '0)); // R11
endmodule

bind tmr_top tmr_chk #(.CNT_W(CNT_W), .EVT_W(EVT_W), .CTRL_W(CTRL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .cnt0        (cnt_bus[0]),
  .ctrl        (ctrl_q),
  .status      (status_q),
  .mask        (mask_q)
);

// File: tb/tmr_top_tb_top.sv
`timescale 1ns/1ps
module tmr_top_tb_top;
  logic        clk, rst_n, ext_tick;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        wr, rd, irq;
  int          n_chk, n_bad;
  logic [31:0] v;

  tmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .ext_tick_i(ext_tick),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // n clock steps on the timers enabled in ctl, then ctl_off applied
  task automatic run(input logic [31:0] ctl, input logic [31:0] ctl_off, input int n);
    bwr(8'h30, ctl);
    idle(n - 1);
    bwr(8'h30, ctl_off);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; ext_tick = 1'b0; addr = '0; wdata = '0; wr = 1'b0; rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values and unmapped addresses
    for (int a = 0; a < 16; a++) begin
      brd(8'(a * 4), v);
      chk("R1 reset", v, 32'h0);
    end
    chk("R11 reset irq", {31'h0, irq}, 32'h0);

    // R1 bank register readback sweep
    for (int t = 0; t < 3; t++)
      for (int r = 0; r < 4; r++)
        bwr(8'(16 * t + 4 * r), 32'hA5000000 ^ 32'(t * 256 + r * 17 + 1));
    for (int t = 0; t < 3; t++)
      for (int r = 0; r < 4; r++) begin
        brd(8'(16 * t + 4 * r), v);
        chk("R1 bank readback", v, 32'hA5000000 ^ 32'(t * 256 + r * 17 + 1));
      end
    brd(8'h3C, v);
    chk("R1 unmapped", v, 32'h0);
    // R2 control readback, run bits clear
    bwr(8'h30, 32'hFFFF_FDB6);
    brd(8'h30, v);
    chk("R2 ctrl readback", v, 32'h1B6);
    bwr(8'h30, 32'h0);
    for (int t = 0; t < 3; t++) begin
      bwr(8'(16 * t + 8), 32'hDEAD0000);
      bwr(8'(16 * t + 12), 32'hDEAD0001);
    end
    bwr(8'h34, 32'h1FF);

    // R3 sweep: down steps on timer 0 and timer 2
    for (int n = 1; n <= 8; n++) begin
      bwr(8'h00, 32'd50);
      run(32'h001, 32'h000, n);
      brd(8'h00, v);
      chk("R3 down sweep t0", v, 32'(50 - n));
      bwr(8'h20, 32'd1000);
      run(32'h040, 32'h000, n + 3);
      brd(8'h20, v);
      chk("R3 down sweep t2", v, 32'(1000 - n - 3));
    end

    // R4 down wrap with reload
    bwr(8'h00, 32'd3);
    bwr(8'h04, 32'd100);
    bwr(8'h34, 32'h1FF);
    run(32'h001, 32'h000, 6);
    brd(8'h00, v);
    chk("R4 reload value", v, 32'd98);
    brd(8'h34, v);
    chk("R4 ovf status", v, 32'h004);
    chk("R11 ovf without enable", {31'h0, irq}, 32'h0);
    bwr(8'h30, 32'h004);
    chk("R11 ovf with enable", {31'h0, irq}, 32'h1);
    bwr(8'h38, 32'h004);
    chk("R11 masked", {31'h0, irq}, 32'h0);
    bwr(8'h38, 32'h000);
    // R10 write 0 keeps, write 1 clears
    bwr(8'h34, 32'h1FB);
    brd(8'h34, v);
    chk("R10 write zero keeps", v, 32'h004);
    bwr(8'h34, 32'h004);
    brd(8'h34, v);
    chk("R10 write one clears", v, 32'h000);
    chk("R11 irq after clear", {31'h0, irq}, 32'h0);

    // R5 up counting with wrap
    for (int n = 1; n <= 4; n++) begin
      bwr(8'h10, 32'hFFFF_FFFE);
      bwr(8'h14, 32'd7);
      bwr(8'h34, 32'h1FF);
      run(32'h208, 32'h200, n);
      brd(8'h10, v);
      chk("R5 up count", v, (n == 1) ? 32'hFFFF_FFFF : 32'(7 + n - 2));
      brd(8'h34, v);
      chk("R5 up ovf flag", v, (n == 1) ? 32'h0 : 32'h020);
    end
    bwr(8'h30, 32'h000);
    bwr(8'h34, 32'h1FF);

    // R9 compare hits, including a reloaded value
    bwr(8'h18, 32'd5);
    bwr(8'h10, 32'd8);
    run(32'h008, 32'h000, 3);
    brd(8'h34, v);
    chk("R9 cmp1 hit", v, 32'h008);
    chk("R11 cmp irq", {31'h0, irq}, 32'h1);
    bwr(8'h34, 32'h1FF);
    bwr(8'h10, 32'd1);
    bwr(8'h14, 32'd40);
    bwr(8'h1C, 32'd40);
    run(32'h008, 32'h000, 2);
    brd(8'h34, v);
    chk("R9 cmp2 on reload", v, 32'h030);
    bwr(8'h34, 32'h1FF);

    // R8 count write during counting
    bwr(8'h20, 32'd500);
    bwr(8'h30, 32'h040);
    idle(4);
    bwr(8'h20, 32'd1000);
    idle(5);
    bwr(8'h30, 32'h000);
    brd(8'h20, v);
    chk("R8 write wins", v, 32'd994);

    // R6 freeze and resume
    idle(10);
    brd(8'h20, v);
    chk("R6 frozen", v, 32'd994);
    run(32'h040, 32'h000, 4);
    brd(8'h20, v);
    chk("R6 resume no reload", v, 32'd990);

    // R7 external ticks
    bwr(8'h00, 32'd200);
    bwr(8'h30, 32'h003);
    for (int p = 0; p < 5; p++) begin
      ext_tick = 1'b1; idle(3);
      ext_tick = 1'b0; idle(3);
    end
    idle(5);
    brd(8'h00, v);
    chk("R7 ext steps", v, 32'd195);
    ext_tick = 1'b1; idle(20);
    ext_tick = 1'b0; idle(5);
    bwr(8'h30, 32'h000);
    brd(8'h00, v);
    chk("R7 held high one step", v, 32'd194);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule